// File: doc/BRIEF.md
# Programming-Status Read Path

This block is the read-data path of a byte-wide nonvolatile memory. When the memory is idle, a read returns whatever the array presents. While a programming cycle runs, every read becomes a status read instead. Data line 7 shows the inverse of bit 7 of the byte most recently loaded for writing. Data line 6 flips from one completed read to the next. Host software can watch either indication to learn when programming has finished, and it may begin at any point in the cycle.

The programming engine is outside this block. It reports its state on the `busy` input, and it pulses `wr_stb` with the byte it accepts. The tri-state driver is modelled by an enable output, `dq_oe`. The data output `dq_out` reads zero whenever that enable is low. All control inputs are active low, as on the memory pins, and they are sampled against the block clock.

Top module: `poll_rd_path`

## Requirements
- R1: `dq_oe` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. Whenever `dq_oe` is 0, `dq_out` is 0x00.
- R2: With `busy`=0, an enabled read returns `arr_q` on all eight bits in the same cycle.
- R3: With `busy`=1, an enabled read returns the inverse of bit 7 of the last written byte on bit 7.
- R4: With `busy`=1, bit 6 of an enabled read is the toggle state. The toggle is 0 at the first read of a programming cycle. It inverts at each clock edge where the read enable was 1 in the previous cycle and is now 0 while `busy`=1.
- R5: With `busy`=1, bits 5 to 0 of an enabled read are bits 5 to 0 of the last written byte.
- R6: The last-written-byte register loads `wr_data` on each clock edge with `wr_stb`=1 and holds otherwise. Reset clears it to 0x00.
- R7: With `busy`=1, the value of `arr_q` has no effect on `dq_out`.
- R8: With `busy`=0, the toggle state is held at 0. Completed reads while idle do not advance it, so each new programming cycle starts at bit 6 = 0.
- R9: The cycle `busy` falls, an enabled read returns true `arr_q` data with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Programming cycle in progress |
| wr_stb | input | 1 | A byte was accepted for programming |
| wr_data | input | 8 | Byte accepted for programming |
| arr_q | input | 8 | Array read data for the current address |
| dq_out | output | 8 | Read data toward the pins |
| dq_oe | output | 1 | Pin driver enable |

## Verification
There are two pieces of internal state: the stored byte and the toggle flip-flop. A wrong stored byte shows up on the very first status read, on bits 7 and 5 to 0. A toggle that fails to clear, or that advances at the wrong time, shows up on bit 6. That error appears on the first read of a cycle, or on the read that follows a completed read. The bench therefore performs several reads in a row within a single programming cycle. It also reads while idle and then starts a fresh cycle, so that a stale toggle is exposed within one read.

// File: rtl/poll_rd_path.sv
module poll_rd_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] arr_q,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              rd_en, rd_q, tog;
  logic [DATA_W-1:0] last_b, status;

  assign rd_en = !ce_n && !oe_n && we_n;
  assign dq_oe = rd_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      last_b <= '0;
    else if (wr_stb) last_b <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (!busy)              tog <= 1'b0;
      else if (rd_q && !rd_en) tog <= ~tog;
    end

  always_comb begin
    status           = last_b;
    status[POLL_BIT] = ~last_b[POLL_BIT];
    status[TOG_BIT]  = tog;
  end

  assign dq_out = !rd_en ? '0 : (busy ? status : arr_q);

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dq_out == '0 && !dq_oe));
  a_r3_poll_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> (dq_out[POLL_BIT] != last_b[POLL_BIT]));
  a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && !rd_en) |=> (tog != $past(tog)));
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tog);
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (last_b == $past(wr_data)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(last_b));
  a_r2_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dq_oe) |-> (dq_out == arr_q));
endmodule

// File: tb/poll_rd_path_test.sv
module poll_rd_path_test;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, busy = 0, wr_stb = 0;
  logic [7:0] wr_data = 0, arr_q = 0, dq_out;
  logic dq_oe;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  poll_rd_path uut (.clk, .rst_n, .ce_n, .oe_n, .we_n, .busy, .wr_stb,
                    .wr_data, .arr_q, .dq_out, .dq_oe);

  typedef struct packed { logic bz; logic [7:0] last; logic [7:0] arr; logic [7:0] exp; } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b0, 8'hA5, 8'h3C, 8'h3C},
    '{1'b1, 8'hA5, 8'h3C, 8'h25},
    '{1'b1, 8'h5A, 8'hFF, 8'h9A},
    '{1'b1, 8'hFF, 8'h00, 8'h3F},
    '{1'b1, 8'h00, 8'hFF, 8'h80},
    '{1'b0, 8'h00, 8'hC3, 8'hC3}};

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_stb = 1; wr_data = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd(string req, logic [7:0] exp);
    @(negedge clk); ce_n = 0; oe_n = 0;
    #1 chk(req, {dq_oe, dq_out}, {1'b1, exp});
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1 chk("R1 reset", {dq_oe, dq_out}, 9'h000);
    repeat (2) @(negedge clk);
    rst_n = 1;
    busy = 1;
    rd("R6 reset clears last byte", 8'h80);
    busy = 0;
    @(negedge clk);

    foreach (VEC[i]) begin
      wr(VEC[i].last);
      busy = VEC[i].bz; arr_q = VEC[i].arr;
      rd(VEC[i].bz ? "R3 R5 status table" : "R2 idle table", VEC[i].exp);
      busy = 0;
      @(negedge clk);
    end

    // R1: gating by each control
    arr_q = 8'h77;
    @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1;
    #1 chk("R1 ce_n high", {dq_oe, dq_out}, 9'h000);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0;
    #1 chk("R1 we_n low", {dq_oe, dq_out}, 9'h000);
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1;
    #1 chk("R1 oe_n high", {dq_oe, dq_out}, 9'h000);
    @(negedge clk); ce_n = 1; oe_n = 1;

    // R4: toggle sequence
    wr(8'h81);
    busy = 1;
    rd("R4 read1", 8'h01);
    rd("R4 read2", 8'h41);
    rd("R4 read3", 8'h01);
    rd("R4 read4", 8'h41);

    // R7: address/array data ignored while busy
    @(negedge clk); ce_n = 0; oe_n = 0; arr_q = 8'h00;
    #1 chk("R7 arr 00", {1'b0, dq_out}, {1'b0, 8'h01});
    @(negedge clk); arr_q = 8'hFF;
    #1 chk("R7 arr FF", {1'b0, dq_out}, {1'b0, 8'h01});
    // R9: busy falls while read held
    @(negedge clk); busy = 0; arr_q = 8'h6E;
    #1 chk("R9 true data at busy fall", {dq_oe, dq_out}, {1'b1, 8'h6E});
    @(negedge clk); ce_n = 1; oe_n = 1;

    // R8: idle reads do not advance toggle; new cycle starts at 0
    arr_q = 8'h12;
    rd("R2 idle read", 8'h12);
    rd("R2 idle read", 8'h12);
    busy = 1;
    rd("R8 new cycle starts 0", 8'h01);
    busy = 0;
    @(negedge clk);
    busy = 1;
    rd("R8 restart after toggle", 8'h01);
    busy = 0;

    // R6: hold without strobe
    @(negedge clk); wr_data = 8'hFF;
    repeat (2) @(negedge clk);
    busy = 1;
    rd("R6 hold without strobe", 8'h01);
    busy = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule